// File: doc/BRIEF.md
# Two-Slot Packet Fetch and Lane Steering Unit

This unit is the fetch front end of a two-slot core whose instruction schedule is fixed by the compiler. Every cycle it presents an 8-byte-aligned packet address to instruction memory. The memory returns two 32-bit instructions side by side. The unit steers the word from the lower address to the ALU/branch decode lane and the word from the higher address to the load/store decode lane. It registers both words, together with the packet address, toward decode.

The unit has no interlocks. It does not compare registers between or within packets, and it never holds one slot back while the other proceeds. Both slots leave together on every accepted cycle, so the peak rate is two instructions per cycle.

The ALU/branch lane can redirect the packet address to a new target. A taken redirect squashes the packet fetched in the same cycle into two nops. A target that is not 8-byte aligned is refused and raises an error flag. The unit also checks that each slot holds an instruction class that slot can execute, and it replaces an illegal instruction with a nop.

The issue side is a valid/ready stream. `issue_valid` rises when the first fetch after reset completes and then stays high. While `issue_ready` is low, the packet address, every issue output and the error flag input are frozen, and any redirect request is ignored. On a cycle with `issue_ready` high the presented packet counts as consumed, and the next packet is registered at that edge.

Top module: `fs_dual_fetch`

## Requirements
- R1: While reset is held, and on the first cycle after it, `imem_addr` equals the RESET_PC parameter, `issue_valid` is 0, both instruction outputs are 32'h0 (the nop), and `alu_bad`, `mem_bad` and `redir_misalign` are 0.
- R2: On a cycle with `issue_ready` high and no taken redirect, `imem_addr` grows by 8 at the next edge. Bits [2:0] of `imem_addr` are always zero.
- R3: One edge after a packet address is presented with `issue_ready` high, `issue_pc` equals that address. `alu_instr` then carries `imem_rdata[31:0]` (the lower-address word) and `mem_instr` carries `imem_rdata[63:32]`, unless R5 or R7 applies.
- R4: An all-zero word is a nop. It is legal in either slot, issues unchanged, and sets no flag.
- R5: Instruction class is taken from bit 31 (the top bit of the 6-bit opcode field [31:26]): 1 means load/store and 0 means ALU/branch. A lower-address word with bit 31 set raises `alu_bad` and issues as nop. A nonzero higher-address word with bit 31 clear raises `mem_bad` and issues as nop. The other slot of the same packet is not affected.
- R6: No hazard check exists. Both slots issue on every accepted cycle, whatever registers they use.
- R7: A redirect is taken when `redir_valid` and `issue_ready` are high and bits [2:0] of `redir_target` are zero. At the next edge `imem_addr` becomes the target, and the packet fetched in that cycle issues as two nops with both bad flags clear.
- R8: A redirect request with a nonzero `redir_target[2:0]` and `issue_ready` high is not followed. `redir_misalign` is high for the following cycle, the address advances by 8, and the fetched packet issues normally.
- R9: While `issue_ready` is low, `imem_addr`, `issue_valid`, `issue_pc`, both instruction outputs and both bad flags hold their values, and a redirect request has no effect.
- R10: `issue_valid` stays low after reset until an edge with `issue_ready` high has registered a packet. From then on it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | AW | Packet address presented to instruction memory |
| imem_rdata | input | 64 | Packet returned for `imem_addr` in the same cycle; [31:0] is the lower-address word |
| redir_valid | input | 1 | Redirect request from the ALU/branch lane |
| redir_target | input | AW | Requested packet address |
| issue_valid | output | 1 | Issue outputs hold a fetched packet |
| issue_ready | input | 1 | Decode accepts the presented packet; when low, the unit stalls |
| issue_pc | output | AW | Address of the issued packet |
| alu_instr | output | 32 | Instruction for the ALU/branch lane |
| mem_instr | output | 32 | Instruction for the load/store lane |
| alu_bad | output | 1 | The ALU/branch slot held a load/store instruction |
| mem_bad | output | 1 | The load/store slot held a non-nop ALU/branch instruction |
| redir_misalign | output | 1 | A misaligned redirect was refused on the previous cycle |

## Verification
Some properties can be checked on every cycle. The assertions cover alignment and the +8 step of the packet address, the jump to a taken target, and the freeze of the address and all issue outputs under stall. They also check that `issue_valid` stays high once set, that a squashed packet issues as nops, that the misalignment flag follows a refused target, and that no issued instruction sits in the wrong lane class. Other behaviour depends on particular memory contents and stimulus sequences, so only the bench scenarios can show it. That covers the exact word-to-lane mapping against memory contents, nops passing untouched, an illegal slot turning to nop while its partner issues intact, redirects being ignored during a stall, and the reset value of the packet address.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned INSTR_W    = 32;
  localparam int unsigned SLOTS      = 2;
  localparam int unsigned PKT_W      = INSTR_W * SLOTS;
  localparam int unsigned PKT_BYTES  = PKT_W / 8;
  localparam int unsigned ALIGN_BITS = $clog2(PKT_BYTES);

  typedef logic [INSTR_W-1:0] instr_t;

  localparam instr_t NOP_WORD = '0;

  typedef enum logic {
    LANE_ALU = 1'b0,
    LANE_MEM = 1'b1
  } lane_e;

  // The top opcode bit separates memory-access opcodes from ALU/branch ones
  function automatic logic is_mem_op(input instr_t w);
    return w[INSTR_W-1];
  endfunction

  function automatic logic is_nop(input instr_t w);
    return w == NOP_WORD;
  endfunction
endpackage

// File: rtl/fs_pc_gen.sv
module fs_pc_gen #(
  parameter int unsigned    AW       = 32,
  parameter logic [AW-1:0]  RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          take,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP = AW'(fs_pkg::PKT_BYTES);
  localparam int unsigned   AB   = fs_pkg::ALIGN_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (advance) begin
      pc <= take ? target : pc + STEP;
    end
  end

  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[AB-1:0] == '0);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !take) |=> pc == $past(pc) + STEP);

  a_r7_pc_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && take) |=> pc == $past(target));

  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc));
endmodule

// File: rtl/fs_redir_filter.sv
module fs_redir_filter #(
  parameter int unsigned AW = 32
) (
  input  logic          advance,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_target,
  output logic          take,
  output logic          misalign
);
  localparam int unsigned AB = fs_pkg::ALIGN_BITS;

  logic aligned;
  logic request;

  assign aligned  = redir_target[AB-1:0] == '0;
  assign request  = advance && redir_valid;
  assign take     = request && aligned;
  assign misalign = request && !aligned;
endmodule

// File: rtl/fs_slot_check.sv
module fs_slot_check
  import fs_pkg::*;
#(
  parameter lane_e LANE = LANE_ALU
) (
  input  instr_t raw,
  output instr_t steered,
  output logic   bad
);
  generate
    if (LANE == LANE_ALU) begin : g_alu
      assign bad = is_mem_op(raw);
    end else begin : g_mem
      assign bad = !is_nop(raw) && !is_mem_op(raw);
    end
  endgenerate

  assign steered = bad ? NOP_WORD : raw;
endmodule

// File: rtl/fs_issue_reg.sv
module fs_issue_reg
  import fs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          squash,
  input  logic [AW-1:0] pc_in,
  input  instr_t        alu_in,
  input  instr_t        mem_in,
  input  logic          alu_bad_in,
  input  logic          mem_bad_in,
  input  logic          misalign_in,
  output logic          valid,
  output logic [AW-1:0] pc_out,
  output instr_t        alu_out,
  output instr_t        mem_out,
  output logic          alu_bad,
  output logic          mem_bad,
  output logic          misalign
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      pc_out   <= '0;
      alu_out  <= NOP_WORD;
      mem_out  <= NOP_WORD;
      alu_bad  <= 1'b0;
      mem_bad  <= 1'b0;
      misalign <= 1'b0;
    end else begin
      misalign <= misalign_in;
      if (advance) begin
        valid  <= 1'b1;
        pc_out <= pc_in;
        if (squash) begin
          alu_out <= NOP_WORD;
          mem_out <= NOP_WORD;
          alu_bad <= 1'b0;
          mem_bad <= 1'b0;
        end else begin
          alu_out <= alu_in;
          mem_out <= mem_in;
          alu_bad <= alu_bad_in;
          mem_bad <= mem_bad_in;
        end
      end
    end
  end

  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(alu_out) && $stable(mem_out) && $stable(pc_out)
                  && $stable(valid) && $stable(alu_bad) && $stable(mem_bad)));

  a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  a_r7_squash_nops: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && squash) |=> (alu_out == NOP_WORD && mem_out == NOP_WORD
                             && !alu_bad && !mem_bad));
endmodule

// File: rtl/fs_dual_fetch.sv
module fs_dual_fetch
  import fs_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [AW-1:0]    imem_addr,
  input  logic [PKT_W-1:0] imem_rdata,
  input  logic             redir_valid,
  input  logic [AW-1:0]    redir_target,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [AW-1:0]    issue_pc,
  output logic [31:0]      alu_instr,
  output logic [31:0]      mem_instr,
  output logic             alu_bad,
  output logic             mem_bad,
  output logic             redir_misalign
);
  logic    advance;
  logic    take;
  logic    misalign_now;
  logic [AW-1:0] pc;
  instr_t  steered [SLOTS];
  logic    bad     [SLOTS];

  assign advance   = issue_ready;
  assign imem_addr = pc;

  fs_redir_filter #(.AW(AW)) u_redir (
    .advance      (advance),
    .redir_valid  (redir_valid),
    .redir_target (redir_target),
    .take         (take),
    .misalign     (misalign_now)
  );

  fs_pc_gen #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .take    (take),
    .target  (redir_target),
    .pc      (pc)
  );

  // Fixed position-to-lane mapping: slot 0 (lower address) feeds ALU/branch
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    fs_slot_check #(.LANE(g == 0 ? LANE_ALU : LANE_MEM)) u_chk (
      .raw     (imem_rdata[g*INSTR_W +: INSTR_W]),
      .steered (steered[g]),
      .bad     (bad[g])
    );
  end

  fs_issue_reg #(.AW(AW)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .squash      (take),
    .pc_in       (pc),
    .alu_in      (steered[0]),
    .mem_in      (steered[1]),
    .alu_bad_in  (bad[0]),
    .mem_bad_in  (bad[1]),
    .misalign_in (misalign_now),
    .valid       (issue_valid),
    .pc_out      (issue_pc),
    .alu_out     (alu_instr),
    .mem_out     (mem_instr),
    .alu_bad     (alu_bad),
    .mem_bad     (mem_bad),
    .misalign    (redir_misalign)
  );

  a_r8_refused_target: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ready && redir_valid && redir_target[ALIGN_BITS-1:0] != '0)
      |=> (redir_misalign && imem_addr == $past(imem_addr) + AW'(PKT_BYTES)));

  a_r3_issue_addr: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ready |=> issue_pc == $past(imem_addr));

  a_r5_alu_lane_class: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !is_mem_op(alu_instr));

  a_r5_mem_lane_class: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !is_nop(mem_instr)) |-> is_mem_op(mem_instr));

  a_r6_both_lanes_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ready |=> issue_valid);
endmodule

// File: tb/fs_dual_fetch_tb.sv
module fs_dual_fetch_tb;
  localparam logic [31:0] RST_PC = 32'h20;
  localparam int NV = 14;
  // {ready, redir_valid, target, expected issue_pc, expected next addr, squashed, misalign}
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0000, 16'h0020, 16'h0028, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h0028, 16'h0030, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h0030, 16'h0038, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h0048, 16'h0038, 16'h0048, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'h0013, 16'h0048, 16'h0050, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h0000, 16'h0048, 16'h0050, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0000, 16'h0048, 16'h0050, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h0050, 16'h0058, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h0038, 16'h0058, 16'h0038, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h0038, 16'h0040, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h0000, 16'h0040, 16'h0000, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0008, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h00F8, 16'h0008, 16'h00F8, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0000, 16'h00F8, 16'h0100, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr;
  logic [63:0] imem_rdata;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_target = '0;
  logic        issue_valid;
  logic        issue_ready = 1'b0;
  logic [31:0] issue_pc;
  logic [31:0] alu_instr, mem_instr;
  logic        alu_bad, mem_bad, redir_misalign;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  // Instruction memory: {higher-address word, lower-address word}
  function automatic logic [63:0] pkt(input int i);
    case (i)
      5: return {32'hAC22_0008, 32'h8C22_0004};
      6: return {32'h2042_0001, 32'h2021_FFFC};
      7: return 64'h0;
      9: return {32'hAC08_0000, 32'h1420_FFFE};
      default: return {32'h8C00_0000 | 32'(i), 32'h0000_0020 | (32'(i) << 11)};
    endcase
  endfunction

  assign imem_rdata = pkt(int'(imem_addr[7:3]));

  fs_dual_fetch #(.AW(32), .RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .redir_valid(redir_valid), .redir_target(redir_target),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_pc(issue_pc),
    .alu_instr(alu_instr), .mem_instr(mem_instr), .alu_bad(alu_bad),
    .mem_bad(mem_bad), .redir_misalign(redir_misalign)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req, input logic [31:0] exp_addr);
    chk(issue_valid == 1'b0, req, 64'(issue_valid), 0);
    chk(alu_instr == 32'h0 && mem_instr == 32'h0, req,
        {mem_instr, alu_instr}, 0);
    chk(!alu_bad && !mem_bad && !redir_misalign, req,
        {alu_bad, mem_bad, redir_misalign}, 0);
    chk(imem_addr == exp_addr, req, 64'(imem_addr), 64'(exp_addr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_idle("R1 in reset", RST_PC);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset, not ready", RST_PC);

    for (int v = 0; v < NV; v++) begin
      logic [51:0] e;
      logic [63:0] p;
      logic [31:0] ex_a, ex_m;
      logic        ex_ab, ex_mb;
      string       tag;
      e = VEC[v];
      issue_ready  = e[51];
      redir_valid  = e[50];
      redir_target = {16'h0, e[49:34]};
      @(negedge clk);
      p = pkt(int'(e[25:21]));
      // R5: class from bit 31; the ALU slot rejects memory ops, the memory slot rejects non-nop ALU ops
      ex_ab = p[31];
      ex_mb = (p[63:32] != 0) && !p[63];
      ex_a  = (e[1] || ex_ab) ? 32'h0 : p[31:0];
      ex_m  = (e[1] || ex_mb) ? 32'h0 : p[63:32];
      if (e[1]) begin
        ex_ab = 1'b0;
        ex_mb = 1'b0;
      end
      tag = e[1] ? "R7" : (!e[51] ? "R9" : "R3");
      chk(issue_valid == 1'b1, "R6 valid every cycle", 64'(issue_valid), 1);
      chk(issue_pc == {16'h0, e[33:18]}, tag, 64'(issue_pc), 64'(e[33:18]));
      chk(imem_addr == {16'h0, e[17:2]}, e[1] ? "R7 target" : "R2 step",
          64'(imem_addr), 64'(e[17:2]));
      chk(imem_addr[2:0] == 3'b000, "R2 alignment", 64'(imem_addr), 0);
      chk(alu_instr == ex_a, {tag, " alu lane"}, 64'(alu_instr), 64'(ex_a));
      chk(mem_instr == ex_m, {tag, " mem lane"}, 64'(mem_instr), 64'(ex_m));
      chk(alu_bad == ex_ab && mem_bad == ex_mb, "R5 flags",
          {alu_bad, mem_bad}, {ex_ab, ex_mb});
      chk(redir_misalign == e[0], "R8 misalign flag", 64'(redir_misalign),
          64'(e[0]));
      if (e[33:18] == 16'h0038 && !e[1])
        chk(alu_instr == 0 && mem_instr == 0 && !alu_bad && !mem_bad,
            "R4 nop pair", {mem_instr, alu_instr}, 0);
    end

    // R1 / R10: reset mid-stream, then stall before the first fetch
    issue_ready = 1'b1;
    redir_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1 mid-run reset", RST_PC);
    issue_ready = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R10 no valid before first fetch", RST_PC);
    issue_ready = 1'b1;
    @(negedge clk);
    chk(issue_valid == 1'b1, "R10 first fetch", 64'(issue_valid), 1);
    chk(issue_pc == RST_PC, "R10 first packet", 64'(issue_pc), 64'(RST_PC));

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule